// File: doc/BRIEF.md
# Indexed Per-Peripheral Clock Generator

This block is a bank of clock-enable generators, one for each peripheral slot. Each slot picks one of several incoming clock-enable strobes, divides it by a programmable ratio and drives a gated one-cycle enable pulse to its peripheral. Every slot holds three settings: a source index, an 8-bit divider and an enable bit.

All slots share one 32-bit control word. Software reaches a slot indirectly. A write with the command bit clear only points the block at a slot. A later read returns that slot's stored settings. A write with the command bit set commits the written settings to the slot named in that same write. Slots 0 and 1 do not exist, and neither does any ID at or above the implemented slot count. The read port has no wait states: `rd_data` always shows the slot that was selected most recently. The block has no streaming data path, so every pin is a plain control or strobe signal with no valid/ready handshake.

Top module: `gen_clk_bank`

## Requirements
- R1: The control word has these fields: slot ID in bits [5:0], source index in bits [10:8], divider in bits [23:16], enable in bit 24 and command in bit 31. Every write, whatever its command bit, latches the ID. `rd_data` always returns the latched ID in bits [5:0], and all bits outside the four fields read as zero.
- R2: A write with bit 31 set to a valid slot whose source index is legal stores the source, divider and enable into that slot. A later read of that slot returns them.
- R3: A write with bit 31 clear changes no stored slot setting, whatever its other fields hold.
- R4: An enabled slot sends exactly one pulse for every (divider + 1) cycles in which its selected source strobe is high. The ratio therefore runs from 1 to 256. The pulse is high for one cycle, in the cycle after the clock edge that sampled the completing source strobe.
- R5: A commit with the enable bit clear stops the slot's pulses but keeps its source and divider, and those still read back.
- R6: A commit to ID 0, ID 1 or any ID at or above NUM_SLOTS changes nothing. A read of such an ID returns zero in the source, divider and enable fields.
- R7: A commit whose source index is NUM_SRC or higher leaves the target slot unchanged.
- R8: A commit to a slot restarts that slot's divide count from zero, so the new ratio begins with a full period.
- R9: After reset every slot holds source 0, divider 0 and enable clear, the latched ID is 0, and no pulses are driven.
- R10: A slot counts only strobes on its selected source. Activity on the other sources produces no pulses from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written when wr_en is high |
| rd_data | output | 32 | Readback of the latched ID and that slot's settings |
| src_tick | input | NUM_SRC | Incoming clock-enable strobes, one per source |
| gclk_en | output | NUM_SLOTS | Generated enable pulse, one per slot |

## Verification
The bench builds the block with NUM_SLOTS = 8 and NUM_SRC = 6. With those values it can visit every valid slot (2 to 7) with every legal source and a set of dividers: 0, 1, 2, 7 and the largest value, 255. In each case it counts pulses over a tick window that is not a whole multiple of the period. The small slot count also lets the bench reach IDs just past the implemented range: 8, and 10, which would alias onto slot 2 if the ID were truncated. The 3-bit source field leaves indices 6 and 7 as illegal values the bench can commit.

// File: rtl/gck_pkg.sv
package gck_pkg;

  localparam int REG_W      = 32;
  localparam int ID_LSB     = 0;
  localparam int ID_W       = 6;
  localparam int SRC_LSB    = 8;
  localparam int SRC_W      = 3;
  localparam int DIV_LSB    = 16;
  localparam int DIV_W      = 8;
  localparam int EN_BIT     = 24;
  localparam int CMD_BIT    = 31;
  localparam int FIRST_SLOT = 2;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
    logic [SRC_W-1:0] src;
  } slot_cfg_t;

  function automatic logic [REG_W-1:0] pack_word(logic [ID_W-1:0] id, slot_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[ID_LSB +: ID_W]   = id;
    w[SRC_LSB +: SRC_W] = c.src;
    w[DIV_LSB +: DIV_W] = c.div;
    w[EN_BIT]           = c.en;
    return w;
  endfunction

  function automatic slot_cfg_t unpack_cfg(logic [REG_W-1:0] w);
    slot_cfg_t c;
    c.src = w[SRC_LSB +: SRC_W];
    c.div = w[DIV_LSB +: DIV_W];
    c.en  = w[EN_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[ID_LSB +: ID_W]   = '1;
    m[SRC_LSB +: SRC_W] = '1;
    m[DIV_LSB +: DIV_W] = '1;
    m[EN_BIT]           = 1'b1;
    m[CMD_BIT]          = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/gck_div.sv
module gck_div
  import gck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             pulse_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             pulse_q;
  logic             wrap;

  assign wrap = (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= step_i & wrap;
      if (step_i) begin
        if (wrap) cnt_q <= '0;
        else      cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pulse_o = pulse_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i);  // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart_i) |-> (cnt_q == '0 && !pulse_o));  // R8

endmodule

// File: rtl/gck_slot.sv
module gck_slot
  import gck_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  slot_cfg_t          new_cfg_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output slot_cfg_t          cfg_o,
  output logic               pulse_o
);

  slot_cfg_t cfg_q;
  logic      tick_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (commit_i) cfg_q <= new_cfg_i;
  end

  always_comb begin
    tick_sel = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cfg_q.src == SRC_W'(s)) tick_sel = src_tick_i[s];
    end
  end

  gck_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (commit_i),
    .step_i    (cfg_q.en & tick_sel),
    .limit_i   (cfg_q.div),
    .pulse_o   (pulse_o)
  );

  assign cfg_o = cfg_q;

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(cfg_q.en && tick_sel));  // R4

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_q.en) |-> !pulse_o);  // R5

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cfg_q.src} < (SRC_W+1)'(NUM_SRC));  // R7

endmodule

// File: rtl/gck_regif.sv
module gck_regif
  import gck_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_SRC   = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [REG_W-1:0]            wr_data_i,
  input  slot_cfg_t [NUM_SLOTS-1:0]   cfg_i,
  output logic [NUM_SLOTS-1:0]        commit_o,
  output slot_cfg_t                   new_cfg_o,
  output logic [REG_W-1:0]            rd_data_o
);

  logic [ID_W-1:0] wr_id;
  logic [ID_W-1:0] sel_id_q;
  logic            cmd;
  logic            id_ok;
  logic            src_ok;
  logic            sel_ok;
  slot_cfg_t       wr_cfg;
  slot_cfg_t       rd_cfg;
  logic            unused_bits;

  function automatic logic slot_exists(logic [ID_W-1:0] id);
    return ({1'b0, id} >= (ID_W+1)'(FIRST_SLOT)) &&
           ({1'b0, id} <  (ID_W+1)'(NUM_SLOTS));
  endfunction

  assign wr_id       = wr_data_i[ID_LSB +: ID_W];
  assign cmd         = wr_data_i[CMD_BIT];
  assign wr_cfg      = unpack_cfg(wr_data_i);
  assign id_ok       = slot_exists(wr_id);
  assign src_ok      = {1'b0, wr_cfg.src} < (SRC_W+1)'(NUM_SRC);
  assign sel_ok      = slot_exists(sel_id_q);
  assign new_cfg_o   = wr_cfg;
  assign unused_bits = ^(wr_data_i & ~field_mask());

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_commit
    assign commit_o[g] = wr_en_i & cmd & id_ok & src_ok & (wr_id == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_id_q <= '0;
    else if (wr_en_i) sel_id_q <= wr_id;
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel_ok && sel_id_q == ID_W'(i)) rd_cfg = cfg_i[i];
    end
  end

  assign rd_data_o = pack_word(sel_id_q, rd_cfg);

  AST_SEL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> sel_id_q == $past(wr_data_i[ID_LSB +: ID_W]));  // R1

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_o));  // R2

  AST_SELECT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[CMD_BIT]) |-> commit_o == '0);  // R3

  AST_BAD_ID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> rd_data_o[REG_W-1:ID_W] == '0);  // R6

  AST_BAD_SRC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && {1'b0, wr_data_i[SRC_LSB +: SRC_W]} >= (SRC_W+1)'(NUM_SRC))
      |-> commit_o == '0);  // R7

endmodule

// File: rtl/gen_clk_bank.sv
module gen_clk_bank
  import gck_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_SRC   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [NUM_SRC-1:0]   src_tick,
  output logic [NUM_SLOTS-1:0] gclk_en
);

  slot_cfg_t [NUM_SLOTS-1:0] cfg_w;
  logic      [NUM_SLOTS-1:0] commit_w;
  slot_cfg_t                 new_cfg_w;
  logic                      unused_low_commit;

  gck_regif #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_SRC   (NUM_SRC)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .cfg_i     (cfg_w),
    .commit_o  (commit_w),
    .new_cfg_o (new_cfg_w),
    .rd_data_o (rd_data)
  );

  assign unused_low_commit = ^commit_w[FIRST_SLOT-1:0];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g < FIRST_SLOT) begin : g_absent
      assign cfg_w[g]   = '0;
      assign gclk_en[g] = 1'b0;
    end else begin : g_live
      gck_slot #(
        .NUM_SRC (NUM_SRC)
      ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit_w[g]),
        .new_cfg_i  (new_cfg_w),
        .src_tick_i (src_tick),
        .cfg_o      (cfg_w[g]),
        .pulse_o    (gclk_en[g])
      );
    end
  end

endmodule

// File: tb/gen_clk_bank_test.sv
module gen_clk_bank_test;

  localparam int CLK_P = 10;
  localparam int NS    = 8;
  localparam int NSRC  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic [NSRC-1:0] src_tick = '0;
  logic [NS-1:0]   gclk_en;

  int n_chk = 0;
  int n_bad = 0;
  int pc[NS];
  int base[NS];

  gen_clk_bank #(.NUM_SLOTS(NS), .NUM_SRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_tick(src_tick), .gclk_en(gclk_en)
  );

  always #(CLK_P/2) clk = ~clk;

  initial for (int i = 0; i < NS; i++) pc[i] = 0;

  always @(posedge clk) begin
    #(CLK_P/4);
    for (int i = 0; i < NS; i++) pc[i] += int'(gclk_en[i]);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int id, int src, int dv, int en);
    logic [31:0] w;
    w = '0;
    w[5:0]   = id[5:0];
    w[10:8]  = src[2:0];
    w[23:16] = dv[7:0];
    w[24]    = en[0];
    return w;
  endfunction

  task automatic wr(bit cmd, int id, int src, int dv, int en);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = mk(id, src, dv, en);
    wr_data[31] = cmd;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic rdchk(int id, logic [31:0] exp, string req, string what);
    wr(1'b0, id, 0, 0, 0);
    chk(rd_data == exp, req, what, rd_data, exp);
  endtask

  task automatic ticks(logic [NSRC-1:0] m, int n);
    repeat (n) begin
      @(negedge clk);
      src_tick = m;
    end
    @(negedge clk);
    src_tick = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic snap();
    for (int i = 0; i < NS; i++) base[i] = pc[i];
  endtask

  function automatic int got(int i);
    return pc[i] - base[i];
  endfunction

  function automatic int others(int sl);
    int s;
    s = 0;
    for (int i = 0; i < NS; i++) if (i != sl) s += got(i);
    return s;
  endfunction

  initial begin
    #(CLK_P * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int divs[5];
    divs = '{0, 1, 2, 7, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(rd_data == 32'h0, "R9", "readback after reset", rd_data, 0);
    chk(gclk_en == '0, "R9", "pulses after reset", gclk_en, 0);
    for (int i = 2; i < NS; i++) rdchk(i, mk(i, 0, 0, 0), "R9", "slot reset value");

    // R1 select write latches ID, unused bits read zero
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h7E00_F8C6; // cmd clear, id 6, junk elsewhere
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk(rd_data == mk(6, 0, 0, 0), "R1", "select latches id", rd_data, mk(6, 0, 0, 0));

    // R4 pulse timing: one cycle after the sampling edge
    wr(1'b1, 2, 0, 0, 1);
    @(negedge clk); src_tick = 6'b000001;
    @(posedge clk); #1;
    chk(gclk_en == 8'b0000_0100, "R4", "pulse in cycle after tick", gclk_en, 8'b0000_0100);
    @(negedge clk); src_tick = '0;
    @(posedge clk); #1;
    chk(gclk_en == '0, "R4", "pulse lasts one cycle", gclk_en, 0);
    wr(1'b1, 2, 0, 0, 0);

    // R2 R4 R5 R10 sweep over slots, sources and dividers
    for (int sl = 2; sl < NS; sl++) begin
      for (int s = 0; s < NSRC; s++) begin
        for (int di = 0; di < 5; di++) begin
          int dv, k, n;
          logic [NSRC-1:0] m;
          dv = divs[di];
          k  = (sl + s) % 3 + 1;
          n  = k * (dv + 1) + dv;
          m  = NSRC'(1) << s;
          wr(1'b1, sl, s, dv, 1);
          rdchk(sl, mk(sl, s, dv, 1), "R2", "committed settings");
          snap();
          ticks(m, n);
          chk(got(sl) == k, "R4", "pulse count", got(sl), k);
          chk(others(sl) == 0, "R4", "no pulses on other slots", others(sl), 0);
          if (dv <= 7) begin
            snap();
            ticks(~m, n);
            chk(got(sl) == 0, "R10", "other sources ignored", got(sl), 0);
          end
          wr(1'b1, sl, s, dv, 0);
          rdchk(sl, mk(sl, s, dv, 0), "R5", "disable keeps src/div");
          if (dv <= 2) begin
            snap();
            ticks('1, 4);
            chk(got(sl) == 0, "R5", "disabled slot silent", got(sl), 0);
          end
        end
      end
    end

    // R3 select write does not modify a slot
    wr(1'b1, 4, 3, 9, 0);
    wr(1'b0, 4, 5, 77, 1);
    chk(rd_data == mk(4, 3, 9, 0), "R3", "select write leaves slot", rd_data, mk(4, 3, 9, 0));
    snap();
    ticks('1, 10);
    chk(got(4) == 0, "R3", "select write does not enable", got(4), 0);

    // R6 invalid IDs
    wr(1'b1, 2, 1, 5, 0);
    for (int j = 0; j < 5; j++) begin
      int ids[5];
      ids = '{0, 1, 8, 10, 63};
      wr(1'b1, ids[j], 2, 3, 1);
      chk(rd_data == mk(ids[j], 0, 0, 0), "R6", "invalid id reads zero", rd_data, mk(ids[j], 0, 0, 0));
    end
    rdchk(2, mk(2, 1, 5, 0), "R6", "no alias onto slot 2");
    snap();
    ticks('1, 20);
    chk(got(0) + got(1) + got(2) == 0, "R6", "no pulses after invalid commits", got(2), 0);

    // R7 illegal source index
    wr(1'b1, 3, 4, 6, 1);
    wr(1'b1, 3, 6, 1, 0);
    rdchk(3, mk(3, 4, 6, 1), "R7", "source 6 ignored");
    wr(1'b1, 3, 7, 2, 0);
    rdchk(3, mk(3, 4, 6, 1), "R7", "source 7 ignored");
    snap();
    ticks(6'b010000, 14);
    chk(got(3) == 2, "R7", "slot still dividing", got(3), 2);
    wr(1'b1, 3, 4, 6, 0);

    // R8 commit restarts the count
    wr(1'b1, 5, 1, 3, 1);
    snap();
    ticks(6'b000010, 2);
    wr(1'b1, 5, 1, 3, 1);
    ticks(6'b000010, 3);
    chk(got(5) == 0, "R8", "count restarted", got(5), 0);
    ticks(6'b000010, 1);
    chk(got(5) == 1, "R8", "first pulse after full period", got(5), 1);
    wr(1'b1, 5, 1, 3, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule